// File: doc/BRIEF.md
# Per-Channel Digital Zero-Run Detector

This block watches a stereo stream of signed PCM samples and raises a separate flag for the left and the right channel. A flag goes high once that channel has delivered a programmed number of back-to-back samples whose value is exactly zero. A sample counts only in a cycle where the sample strobe is high. A control interface reads the two flags. Any muting or power decision based on them is made elsewhere.

A 2-bit code picks the run length from four counts that are not powers of two. An enable bit switches detection on and off. Changing the code, or clearing the enable, throws away any run in progress. Once a channel reaches its run length, its counter stops there. The flag then stays up for as long as zeros keep arriving on that channel.

Top module: `zero_run_monitor`

## Requirements
- R1: A channel's flag rises on the clock edge that accepts the Nth consecutive strobed zero sample on that channel, where N is the selected run length. It is low after every edge before that one.
- R2: The run length is N = 3200 for `len_sel` = 0, 4800 for 1, 9600 for 2 and 19600 for 3.
- R3: The left and right channels count and flag independently. Samples on one channel never move the other channel's flag.
- R4: A strobed sample with any nonzero value clears that channel's count and flag on the same edge. This includes the all-ones pattern (-1).
- R5: Once a channel has reached N, each further strobed zero keeps its flag high, without limit and with no wrap of the counter.
- R6: A cycle with `smp_valid` low changes neither count nor flag, provided `det_en` is high and `len_sel` is unchanged.
- R7: When `det_en` is sampled low, both counts and both flags are zero after that edge. After re-enabling, a full N zeros are needed again.
- R8: When `len_sel` differs from its value in the previous cycle, both counts and both flags restart at zero on that edge. A sample strobed in that same cycle is not counted.
- R9: `rst` is synchronous and active high. It clears both flags and both counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Detection enable |
| len_sel | input | 2 | Run-length code (0:3200, 1:4800, 2:9600, 3:19600) |
| smp_valid | input | 1 | Sample strobe for both channels |
| smp_left | input | SAMPLE_W | Signed left-channel sample |
| smp_right | input | SAMPLE_W | Signed right-channel sample |
| quiet_left | output | 1 | Left channel has seen N consecutive zeros |
| quiet_right | output | 1 | Right channel has seen N consecutive zeros |

## Verification
The bench probes the edge at N-1 versus N zeros for every code. A design that is off by one in its threshold would flag one sample early or one sample late, and a wrong entry in the length table would flag at the wrong count. Runs continue far past N and include idle strobe-low gaps. A counter that wraps would drop the flag during the run, and one that counts unstrobed cycles would raise it early. A -1 sample on one channel and a change of code in the middle of a run are also applied. A design that tests only the sign bit, shares one counter between the channels, or keeps the sample that arrives with a code change would either leave a flag high or raise it one sample early.

// File: rtl/zrm_pkg.sv
package zrm_pkg;

    localparam int unsigned RUN_LEN_C0 = 3200;
    localparam int unsigned RUN_LEN_C1 = 4800;
    localparam int unsigned RUN_LEN_C2 = 9600;
    localparam int unsigned RUN_LEN_C3 = 19600;
    localparam int unsigned RUN_LEN_TOP = RUN_LEN_C3;
    localparam int unsigned RUN_CNT_W = $clog2(RUN_LEN_TOP + 1);
    localparam int unsigned NUM_CHAN = 2;

    typedef logic [RUN_CNT_W-1:0] run_cnt_t;

    typedef enum logic [1:0] {
        RUN_CODE_SHORT = 2'd0,
        RUN_CODE_MID   = 2'd1,
        RUN_CODE_LONG  = 2'd2,
        RUN_CODE_MAX   = 2'd3
    } run_code_e;

    typedef enum logic [1:0] {
        CH_HOLD  = 2'd0,
        CH_CLEAR = 2'd1,
        CH_ZERO  = 2'd2
    } chan_act_e;

    typedef struct packed {
        run_cnt_t cnt;
        logic     quiet;
    } run_state_t;

    function automatic run_cnt_t run_limit(input run_code_e code);
        run_cnt_t lim;
        unique case (code)
            RUN_CODE_SHORT: lim = run_cnt_t'(RUN_LEN_C0);
            RUN_CODE_MID:   lim = run_cnt_t'(RUN_LEN_C1);
            RUN_CODE_LONG:  lim = run_cnt_t'(RUN_LEN_C2);
            default:        lim = run_cnt_t'(RUN_LEN_C3);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/zrm_limit_decode.sv
module zrm_limit_decode
    import zrm_pkg::*;
(
    input  logic [1:0] code,
    output run_cnt_t   limit
);
    always_comb begin
        limit = run_limit(run_code_e'(code));
    end
endmodule

// File: rtl/zrm_ctrl.sv
module zrm_ctrl (
    input  logic       clk,
    input  logic       rst,
    input  logic       det_en,
    input  logic [1:0] len_sel,
    output logic       restart
);
    logic [1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 2'd0;
        else     sel_q <= len_sel;
    end

    always_comb begin
        restart = !det_en || (len_sel != sel_q);
    end
endmodule

// File: rtl/zrm_chan.sv
module zrm_chan
    import zrm_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  run_cnt_t            limit,
    output logic                quiet
);
    run_state_t st_q, st_d;
    chan_act_e  act;
    logic       is_zero;
    logic       at_limit;
    run_cnt_t   cnt_inc;

    always_comb begin
        is_zero  = (sample == '0);
        at_limit = (st_q.cnt >= limit);
        cnt_inc  = st_q.cnt + run_cnt_t'(1);
        if (restart)      act = CH_CLEAR;
        else if (!valid)  act = CH_HOLD;
        else if (is_zero) act = CH_ZERO;
        else              act = CH_CLEAR;
    end

    always_comb begin
        st_d = st_q;
        unique case (act)
            CH_CLEAR: begin
                st_d.cnt   = '0;
                st_d.quiet = 1'b0;
            end
            CH_ZERO: begin
                if (at_limit) begin
                    st_d.cnt   = limit;
                    st_d.quiet = 1'b1;
                end else begin
                    st_d.cnt   = cnt_inc;
                    st_d.quiet = (cnt_inc == limit);
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign quiet = st_q.quiet;
endmodule

// File: rtl/zero_run_monitor.sv
module zero_run_monitor
    import zrm_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                det_en,
    input  logic [1:0]          len_sel,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                quiet_left,
    output logic                quiet_right
);
    logic                restart;
    run_cnt_t            limit;
    logic [SAMPLE_W-1:0] ch_sample [NUM_CHAN];
    logic                ch_quiet  [NUM_CHAN];

    assign ch_sample[0] = smp_left;
    assign ch_sample[1] = smp_right;

    zrm_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .det_en  (det_en),
        .len_sel (len_sel),
        .restart (restart)
    );

    zrm_limit_decode u_limit (
        .code  (len_sel),
        .limit (limit)
    );

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        zrm_chan #(.SAMPLE_W(SAMPLE_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .restart (restart),
            .valid   (smp_valid),
            .sample  (ch_sample[ch]),
            .limit   (limit),
            .quiet   (ch_quiet[ch])
        );
    end

    assign quiet_left  = ch_quiet[0];
    assign quiet_right = ch_quiet[1];
endmodule

// File: rtl/zero_run_monitor_chk.sv
module zero_run_monitor_chk #(
    parameter int unsigned SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst,
    input logic                det_en,
    input logic [1:0]          len_sel,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_left,
    input logic [SAMPLE_W-1:0] smp_right,
    input logic                quiet_left,
    input logic                quiet_right
);
    a_r4_nonzero_clears_left: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_left != '0) |=> !quiet_left);
    a_r4_nonzero_clears_right: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_right != '0) |=> !quiet_right);
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> (!quiet_left && !quiet_right));
    a_r8_sel_change_clears: assert property (@(posedge clk) disable iff (rst)
        !$stable(len_sel) |=> (!quiet_left && !quiet_right));
    a_r6_idle_holds_left: assert property (@(posedge clk) disable iff (rst)
        (det_en && !smp_valid && $stable(len_sel)) |=> $stable(quiet_left));
    a_r6_idle_holds_right: assert property (@(posedge clk) disable iff (rst)
        (det_en && !smp_valid && $stable(len_sel)) |=> $stable(quiet_right));
    a_r1_rise_on_zero_left: assert property (@(posedge clk) disable iff (rst)
        $rose(quiet_left) |-> $past(det_en && smp_valid && smp_left == '0));
    a_r1_rise_on_zero_right: assert property (@(posedge clk) disable iff (rst)
        $rose(quiet_right) |-> $past(det_en && smp_valid && smp_right == '0));
endmodule

bind zero_run_monitor zero_run_monitor_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/zero_run_monitor_bench.sv
module zero_run_monitor_bench;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         det_en = 1'b0;
    logic [1:0]   len_sel = 2'd0;
    logic         smp_valid = 1'b0;
    logic [W-1:0] smp_left = '0;
    logic [W-1:0] smp_right = '0;
    logic         quiet_left, quiet_right;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    int ref_cnt_l = 0, ref_cnt_r = 0, ref_prev_sel = 0;
    bit ref_q_l = 0, ref_q_r = 0;

    always #5 clk = ~clk;

    zero_run_monitor #(.SAMPLE_W(W)) u_zero_run_monitor (
        .clk(clk), .rst(rst), .det_en(det_en), .len_sel(len_sel),
        .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
        .quiet_left(quiet_left), .quiet_right(quiet_right)
    );

    function automatic int run_len(input int code);
        case (code)
            0: return 3200;
            1: return 4800;
            2: return 9600;
            default: return 19600;
        endcase
    endfunction

    always @(posedge clk) begin
        int n;
        bit rs;
        n = run_len(int'(len_sel));
        if (rst) begin
            ref_cnt_l = 0; ref_cnt_r = 0; ref_prev_sel = 0;
        end else begin
            rs = !det_en || (int'(len_sel) != ref_prev_sel);
            ref_prev_sel = int'(len_sel);
            if (rs) begin
                ref_cnt_l = 0; ref_cnt_r = 0;
            end else if (smp_valid) begin
                ref_cnt_l = (smp_left == 0)  ? ((ref_cnt_l < n) ? ref_cnt_l + 1 : n) : 0;
                ref_cnt_r = (smp_right == 0) ? ((ref_cnt_r < n) ? ref_cnt_r + 1 : n) : 0;
            end
        end
        ref_q_l = (ref_cnt_l >= n) && (ref_cnt_l > 0);
        ref_q_r = (ref_cnt_r >= n) && (ref_cnt_r > 0);
    end

    task automatic check(input string tag, input bit act, input bit exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // per-clock comparison against the model (R1 R3 R4 R5 R6 R7 R8)
    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            check("R1 model left", quiet_left, ref_q_l);
            check("R3 model right", quiet_right, ref_q_r);
        end
    end

    task automatic drive(input bit v, input logic [W-1:0] l, input logic [W-1:0] r);
        @(negedge clk);
        smp_valid = v; smp_left = l; smp_right = r;
    endtask

    task automatic run_zeros(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, '0, '0);
    endtask

    // sample outputs at the negedge after the last driven edge
    task automatic expect_both(input string tag, input bit l, input bit r);
        @(negedge clk);
        smp_valid = 1'b0;
        check(tag, quiet_left, l);
        check(tag, quiet_right, r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset left", quiet_left, 1'b0);
        check("R9 reset right", quiet_right, 1'b0);
        rst = 1'b0; det_en = 1'b1; len_sel = 2'd0;
        drive(1'b0, '0, '0);

        // R1 R2 code 0 threshold edge
        run_zeros(3199);
        expect_both("R1 below threshold", 1'b0, 1'b0);
        run_zeros(1);
        expect_both("R2 code0 at 3200", 1'b1, 1'b1);

        // R5 saturation
        run_zeros(600);
        expect_both("R5 saturate", 1'b1, 1'b1);

        // R6 idle cycles
        repeat (20) drive(1'b0, 24'h123456, 24'h000001);
        expect_both("R6 idle hold", 1'b1, 1'b1);

        // R4 R3 all-ones on right only
        drive(1'b1, '0, '1);
        expect_both("R4 R3 right -1 clears", 1'b1, 1'b0);
        drive(1'b1, 24'h000001, '0);
        expect_both("R4 left nonzero clears", 1'b0, 1'b0);

        // R7 disable
        run_zeros(3200);
        expect_both("R1 rebuild", 1'b1, 1'b1);
        @(negedge clk); det_en = 1'b0; smp_valid = 1'b1; smp_left = '0; smp_right = '0;
        @(negedge clk); det_en = 1'b1; smp_valid = 1'b0;
        check("R7 disable left", quiet_left, 1'b0);
        check("R7 disable right", quiet_right, 1'b0);
        run_zeros(3199);
        expect_both("R7 full run needed", 1'b0, 1'b0);
        run_zeros(1);
        expect_both("R7 reenabled", 1'b1, 1'b1);

        // R8 select change, sample in change cycle not counted; R2 other codes
        for (int code = 1; code < 4; code++) begin
            @(negedge clk); len_sel = 2'(code); smp_valid = 1'b1; smp_left = '0; smp_right = '0;
            expect_both("R8 change clears", 1'b0, 1'b0);
            run_zeros(run_len(code) - 1);
            expect_both("R8 change sample not counted", 1'b0, 1'b0);
            run_zeros(1);
            expect_both("R2 code threshold", 1'b1, 1'b1);
        end

        // R3 left-only run under code 0
        @(negedge clk); len_sel = 2'd0; smp_valid = 1'b0;
        for (int i = 0; i < 3200; i++) drive(1'b1, '0, 24'h800000);
        expect_both("R3 independent", 1'b1, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule